// File: doc/BRIEF.md
# External ROM Select and Bus Direction Controller

This block drives the active-low select line of an external ROM in a system made of one controller device and one ROM device. It also decides when the controller drives the shared external data bus. A mode bit in a small control register picks between two behaviours.

In decoded mode, the select goes low only for the upper part of the address space, and only during the high half of the bus-phase clock. The data bus then works in both directions. In quiet mode, the select is held low all the time and the data bus is never driven. This keeps the select and bus lines from switching, which cuts radiated noise.

The low 512 bytes of the address space always belong to internal memory. For those addresses the read-data select picks internal data in both modes. The block also holds the direction registers of the two ports that share pins with the bus. Their reset values make the bus-clock pin an output and every other pin an input.

Top module: `ext_rom_select`

## Requirements
- R1: With the mode bit at 1 and `bus_phase` high, `rom_sel_n` is 0 exactly when `cpu_addr` is 0x3000 or higher, and 1 otherwise.
- R2: With the mode bit at 1 and `bus_phase` low, `rom_sel_n` is 1 for every address.
- R3: With the mode bit at 0, `rom_sel_n` is 0 for every address, every phase and both transfer directions.
- R4: With the mode bit at 0, `xbus_oe` is 0 at all times, so the data bus is input only.
- R5: With the mode bit at 1, `xbus_oe` is 1 exactly when `cpu_rw_n` is 0 (write), `cpu_addr` is 0x0200 or higher, and `bus_phase` is high.
- R6: `rdata_ext_sel` is 0 (internal data) for addresses 0x0000 to 0x01FF and 1 (pin data) for every other address, in both modes.
- R7: A clock edge with `cpu_rw_n` at 0 and `cpu_addr` equal to 0x000C loads `cpu_wdata` bit 0 into the mode bit. The mode bit appears on `ext_mode`. Reading 0x000C returns the mode bit in bit 0 of `reg_rdata` and zeros in the other bits.
- R8: After reset, the mode bit is 1, `bport_dir` is 0x01 (bit 0 is an output, all other bits are inputs; a bit value of 1 means output), and `aux_dir` is 0x0.
- R9: A write edge at 0x0004 loads all 8 bits of `cpu_wdata` into `bport_dir`. A write edge at 0x0005 loads bits 3:0 into `aux_dir`. Reads at these addresses return the register, with the unused upper bits of the auxiliary register read as 0. Any other address reads 0.
- R10: `bport_clk_o` follows `bus_phase` in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_rw_n | input | 1 | 1 = read, 0 = write |
| cpu_wdata | input | 8 | CPU write data for the registers |
| bus_phase | input | 1 | Bus-phase clock; high half is the transfer window |
| rom_sel_n | output | 1 | Active-low external ROM select |
| xbus_oe | output | 1 | Drive enable for the external data bus |
| rdata_ext_sel | output | 1 | 1 = take read data from the pins, 0 = internal |
| reg_rdata | output | 8 | Read data from the block's registers |
| ext_mode | output | 1 | Current mode bit |
| bport_dir | output | 8 | Direction bits of the bus/address port |
| aux_dir | output | 4 | Direction bits of the auxiliary port |
| bport_clk_o | output | 1 | Bus-phase clock sent to port bit 0 |

## Verification
The bench sweeps every high address byte, combined with low bytes 0x00 and 0xFF, across both phases, both directions and both modes. This covers the 0x01FF/0x0200 and 0x2FFF/0x3000 boundaries exactly.

An off-by-one decode would move the select edge or the internal-data window by one page. A missing phase gate would assert the select during the low half of the clock. A quiet mode that still drives the bus would raise `xbus_oe` on writes.

Register tests check the reset values, loading the mode bit from bit 0 only, and the read-back masking. A wrong reset value would start the part in quiet mode or make the bus-clock pin an input.

// File: rtl/ers_pkg.sv
package ers_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;

  typedef struct packed {
    logic internal;
    logic rom_window;
    logic ext_space;
    logic hit_ctrl;
    logic hit_bdir;
    logic hit_adir;
  } dec_t;
endpackage

// File: rtl/ers_addr_decode.sv
module ers_addr_decode
  import ers_pkg::*;
#(
  parameter addr_t INT_LAST  = 16'h01FF,
  parameter addr_t ROM_FIRST = 16'h3000,
  parameter addr_t CTRL_ADDR = 16'h000C,
  parameter addr_t BDIR_ADDR = 16'h0004,
  parameter addr_t ADIR_ADDR = 16'h0005
) (
  input  addr_t addr,
  output dec_t  dec
);
  always_comb begin
    dec.internal   = (addr <= INT_LAST);
    dec.ext_space  = (addr > INT_LAST);
    dec.rom_window = (addr >= ROM_FIRST);
    dec.hit_ctrl   = (addr == CTRL_ADDR);
    dec.hit_bdir   = (addr == BDIR_ADDR);
    dec.hit_adir   = (addr == ADIR_ADDR);
  end
endmodule

// File: rtl/ers_cfg_regs.sv
module ers_cfg_regs
  import ers_pkg::*;
#(
  parameter int   BPORT_W   = 8,
  parameter int   AUX_W     = 4,
  parameter logic MODE_RST  = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  dec_t               dec,
  input  data_t              wdata,
  output logic               mode,
  output logic [BPORT_W-1:0] bdir,
  output logic [AUX_W-1:0]   adir,
  output data_t              rdata
);
  localparam logic [BPORT_W-1:0] BDIR_RST = BPORT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= MODE_RST;
      bdir <= BDIR_RST;
    end else if (wr) begin
      if (dec.hit_ctrl) mode <= wdata[0];
      if (dec.hit_bdir) bdir <= wdata[BPORT_W-1:0];
    end
  end

  for (genvar i = 0; i < AUX_W; i++) begin : g_aux
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    adir[i] <= 1'b0;
      else if (wr && dec.hit_adir)   adir[i] <= wdata[i];
    end
  end

  always_comb begin
    rdata = '0;
    if (dec.hit_ctrl)      rdata[0]         = mode;
    else if (dec.hit_bdir) rdata[BPORT_W-1:0] = bdir;
    else if (dec.hit_adir) rdata[AUX_W-1:0]   = adir;
  end
endmodule

// File: rtl/ers_pin_drive.sv
module ers_pin_drive
  import ers_pkg::*;
(
  input  logic mode,
  input  dec_t dec,
  input  logic wr,
  input  logic phase,
  output logic sel_n,
  output logic oe,
  output logic ext_sel
);
  always_comb begin
    if (mode) begin
      sel_n = ~(phase & dec.rom_window);
      oe    = phase & wr & dec.ext_space;
    end else begin
      sel_n = 1'b0;
      oe    = 1'b0;
    end
    ext_sel = ~dec.internal;
  end
endmodule

// File: rtl/ext_rom_select.sv
module ext_rom_select
  import ers_pkg::*;
#(
  parameter int BPORT_W = 8,
  parameter int AUX_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [15:0]        cpu_addr,
  input  logic               cpu_rw_n,
  input  logic [7:0]         cpu_wdata,
  input  logic               bus_phase,
  output logic               rom_sel_n,
  output logic               xbus_oe,
  output logic               rdata_ext_sel,
  output logic [7:0]         reg_rdata,
  output logic               ext_mode,
  output logic [BPORT_W-1:0] bport_dir,
  output logic [AUX_W-1:0]   aux_dir,
  output logic               bport_clk_o
);
  dec_t dec;
  logic wr;
  assign wr = ~cpu_rw_n;

  ers_addr_decode u_dec (.addr(cpu_addr), .dec(dec));

  ers_cfg_regs #(.BPORT_W(BPORT_W), .AUX_W(AUX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(wr), .dec(dec), .wdata(cpu_wdata),
    .mode(ext_mode), .bdir(bport_dir), .adir(aux_dir), .rdata(reg_rdata)
  );

  ers_pin_drive u_pins (
    .mode(ext_mode), .dec(dec), .wr(wr), .phase(bus_phase),
    .sel_n(rom_sel_n), .oe(xbus_oe), .ext_sel(rdata_ext_sel)
  );

  assign bport_clk_o = bus_phase;
endmodule

// File: rtl/ext_rom_select_chk.sv
module ext_rom_select_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cpu_addr,
  input logic        cpu_rw_n,
  input logic [7:0]  cpu_wdata,
  input logic        bus_phase,
  input logic        rom_sel_n,
  input logic        xbus_oe,
  input logic        rdata_ext_sel,
  input logic        ext_mode
);
  AST_SEL_BELOW_ROM: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode && cpu_addr < 16'h3000) |-> rom_sel_n); // R1
  AST_SEL_PHASE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode && !bus_phase) |-> rom_sel_n); // R2
  AST_SEL_QUIET_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_mode |-> !rom_sel_n); // R3
  AST_QUIET_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_mode |-> !xbus_oe); // R4
  AST_OE_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    xbus_oe |-> (!cpu_rw_n && bus_phase && cpu_addr >= 16'h0200)); // R5
  AST_INTERNAL_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr <= 16'h01FF) |-> !rdata_ext_sel); // R6
  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_rw_n && cpu_addr == 16'h000C) |=> (ext_mode == $past(cpu_wdata[0]))); // R7
endmodule

bind ext_rom_select ext_rom_select_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rw_n(cpu_rw_n),
  .cpu_wdata(cpu_wdata), .bus_phase(bus_phase), .rom_sel_n(rom_sel_n),
  .xbus_oe(xbus_oe), .rdata_ext_sel(rdata_ext_sel), .ext_mode(ext_mode)
);

// File: tb/ext_rom_select_tb_top.sv
module ext_rom_select_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_rw_n = 1'b1;
  logic [7:0]  cpu_wdata = '0;
  logic        bus_phase = 1'b0;
  logic        rom_sel_n, xbus_oe, rdata_ext_sel, ext_mode, bport_clk_o;
  logic [7:0]  reg_rdata, bport_dir;
  logic [3:0]  aux_dir;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  ext_rom_select dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rw_n(cpu_rw_n),
    .cpu_wdata(cpu_wdata), .bus_phase(bus_phase), .rom_sel_n(rom_sel_n),
    .xbus_oe(xbus_oe), .rdata_ext_sel(rdata_ext_sel), .reg_rdata(reg_rdata),
    .ext_mode(ext_mode), .bport_dir(bport_dir), .aux_dir(aux_dir),
    .bport_clk_o(bport_clk_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h addr=%04h rw_n=%0b ph=%0b",
               req, act, exp, cpu_addr, cpu_rw_n, bus_phase);
    end
  endtask

  task automatic reg_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_rw_n = 1'b0; cpu_wdata = d;
    @(negedge clk);
    cpu_rw_n = 1'b1; cpu_addr = 16'h0100;
  endtask

  task automatic reg_read(input logic [15:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    cpu_addr = a; cpu_rw_n = 1'b1;
    #1 chk(req, reg_rdata, exp);
  endtask

  task automatic sweep(input logic m);
    for (int hi = 0; hi < 256; hi++) begin
      for (int lo = 0; lo < 2; lo++) begin
        for (int ph = 0; ph < 2; ph++) begin
          for (int rw = 0; rw < 2; rw++) begin
            logic [15:0] a;
            logic e_sel, e_oe, e_ext;
            a = {hi[7:0], (lo == 1) ? 8'hFF : 8'h00};
            @(negedge clk);
            cpu_addr = a; bus_phase = ph[0]; cpu_rw_n = rw[0];
            #1;
            e_ext = (a >= 16'h0200);
            e_sel = m ? !(ph[0] && a >= 16'h3000) : 1'b0;
            e_oe  = m ? (ph[0] && !rw[0] && a >= 16'h0200) : 1'b0;
            if (m) chk(ph[0] ? "R1" : "R2", rom_sel_n, e_sel);
            else   chk("R3", rom_sel_n, e_sel);
            chk(m ? "R5" : "R4", xbus_oe, e_oe);
            chk("R6", rdata_ext_sel, e_ext);
            chk("R10", bport_clk_o, ph[0]);
          end
        end
      end
    end
    cpu_rw_n = 1'b1;
  endtask

  initial begin
    #(CLK_P * 5000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8", ext_mode, 1'b1);
    chk("R8", bport_dir, 8'h01);
    chk("R8", aux_dir, 4'h0);
    reg_read(16'h000C, 8'h01, "R7");

    sweep(1'b1);

    reg_write(16'h000C, 8'hFE);
    chk("R7", ext_mode, 1'b0);
    reg_read(16'h000C, 8'h00, "R7");
    sweep(1'b0);

    reg_write(16'h000C, 8'h03);
    chk("R7", ext_mode, 1'b1);
    reg_read(16'h000C, 8'h01, "R7");

    reg_write(16'h0004, 8'hA5);
    chk("R9", bport_dir, 8'hA5);
    reg_write(16'h0005, 8'hFB);
    chk("R9", aux_dir, 4'hB);
    reg_read(16'h0004, 8'hA5, "R9");
    reg_read(16'h0005, 8'h0B, "R9");
    reg_read(16'h0006, 8'h00, "R9");
    chk("R9", ext_mode, 1'b1);

    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R8", bport_dir, 8'h01);
    chk("R8", aux_dir, 4'h0);
    chk("R8", ext_mode, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule